// File: doc/BRIEF.md
# Multichannel ADC Conversion Sequencer

This block runs conversion sequences for an eight-input analog-to-digital converter. A start pulse captures a four-bit source code and three mode bits. The sequencer then asks an external converter for one result at a time. It presents a source code and a one-cycle request strobe, waits for the converter's done pulse, and stores the returned sample in one of eight result registers. When the last result of the sequence has been stored, it raises a completion flag.

In multichannel mode the input channel advances with each conversion and wraps modulo eight. Result register n therefore always holds input ((start + n) mod 8), whichever channel the sequence began on. In single-channel mode the same source is converted again and again. A one-shot mode performs exactly one conversion. The source code's top bit picks external inputs or internal reference sources. Some internal codes are reserved, and for those a zero result is stored.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset all eight result registers read zero, the completion flag is low and no request is raised.
- R2: With multichannel set and the eight-conversion bit set, result register n (bits n*DATA_W upward of the result bus) receives the conversion of source code {sel_i[3], (sel_i[2:0] + n) mod 8}. The channel wraps past 7 to 0, so a start of 3 fills registers 0..7 from channels 3,4,5,6,7,0,1,2.
- R3: With multichannel set, the eight-conversion bit clear and one-shot clear, exactly four conversions run, and registers 0..3 receive channels (start + n) mod 8. Registers 4..7 keep their earlier values.
- R4: With multichannel clear, every conversion of the sequence uses the full four-bit sel_i code. There are four of them, or eight when the eight-conversion bit is set, and they are stored in registers 0 upward.
- R5: With the eight-conversion bit clear and one-shot set, a sequence is exactly one conversion, stored in register 0. The eight-conversion bit, when set, overrides one-shot.
- R6: conv_req_o is high for a single cycle per conversion. No further request is raised until a conv_done_i pulse has been accepted while waiting. A done pulse at any other time changes no register and no flag.
- R7: A start pulse at any time (running or idle) aborts the current sequence and clears the completion flag. It begins again from register 0 with the newly presented code and mode bits.
- R8: seq_done_o rises in the cycle after the clock edge that writes the last result. It stays high until a start pulse or ack_i clears it.
- R9: conv_chan_o is {internal-select bit, 3-bit channel}. Internal codes 4, 5 and 6 (sel bit 3 = 1) are valid. Internal codes 0, 1, 2, 3 and 7 are reserved: they are still requested, but zero is stored in place of the returned data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start or restart pulse; captures sel_i and mode bits |
| sel_i | input | 4 | Bit 3 selects internal sources, bits 2:0 the channel or start channel |
| multi_i | input | 1 | 1 = channel advances each conversion, 0 = repeat one source |
| len8_i | input | 1 | 1 = eight conversions per sequence |
| once_i | input | 1 | With len8_i = 0, 1 = single conversion |
| ack_i | input | 1 | Clears the completion flag |
| conv_req_o | output | 1 | One-cycle conversion request |
| conv_chan_o | output | 4 | Source code for the requested conversion |
| conv_done_i | input | 1 | Converter done pulse, qualifies conv_data_i |
| conv_data_i | input | DATA_W | Converted sample |
| res_o | output | 8*DATA_W | Result registers, register n at bits n*DATA_W upward |
| seq_done_o | output | 1 | Sequence complete flag |

## Verification
The multichannel path is run from start codes 3, 0 and 6. These separate correct modulo-eight wrap from saturating or unwrapped indexing, and a four-long run starting at 6 shows whether registers 4..7 are left alone. Single-channel runs of four and eight, and one-shot runs with the eight-conversion bit both clear and set, show whether the length decode gives the right priority. Internal-source runs mix valid and reserved codes in one sequence, so a zero in the wrong register stands out. A mid-sequence restart, a done pulse in idle, and ack/restart after completion check the abort, ignore and flag-clearing rules.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int NUM_CH    = 8;
    localparam int CH_W      = $clog2(NUM_CH);
    localparam int SEL_W     = CH_W + 1;
    localparam int SHORT_LEN = 4;

    // internal source codes that carry a real reference; the rest are reserved
    localparam logic [NUM_CH-1:0] INT_VALID = 8'b0111_0000;

    typedef struct packed {
        logic            src_int;
        logic [CH_W-1:0] base;
        logic            multi;
        logic            len8;
        logic            once;
    } seq_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_FIN
    } seq_st_t;

    typedef struct packed {
        seq_st_t         st;
        seq_cfg_t        cfg;
        logic [CH_W-1:0] idx;
        logic            done;
    } seq_ctl_t;

endpackage

// File: rtl/adc_seq_len_dec.sv
module adc_seq_len_dec
    import adc_seq_pkg::*;
(
    input  logic            len8,
    input  logic            once,
    output logic [CH_W-1:0] last_idx
);

    localparam logic [CH_W-1:0] LAST_LONG  = CH_W'(NUM_CH - 1);
    localparam logic [CH_W-1:0] LAST_SHORT = CH_W'(SHORT_LEN - 1);

    always_comb begin
        if (len8) begin
            last_idx = LAST_LONG;
        end else if (once) begin
            last_idx = '0;
        end else begin
            last_idx = LAST_SHORT;
        end
    end

endmodule

// File: rtl/adc_seq_chan_map.sv
module adc_seq_chan_map
    import adc_seq_pkg::*;
(
    input  logic             src_int,
    input  logic [CH_W-1:0]  base,
    input  logic             multi,
    input  logic [CH_W-1:0]  idx,
    output logic [SEL_W-1:0] chan,
    output logic             rsv
);

    logic [CH_W-1:0] ch_low;

    always_comb begin
        // the CH_W-bit sum wraps naturally modulo NUM_CH
        ch_low = multi ? CH_W'(base + idx) : base;
        chan   = {src_int, ch_low};
        rsv    = src_int && !INT_VALID[ch_low];
    end

endmodule

// File: rtl/adc_seq_res_bank.sv
module adc_seq_res_bank #(
    parameter int DATA_W = 10,
    parameter int NUM    = 8,
    localparam int AW    = $clog2(NUM)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [AW-1:0]         waddr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [NUM*DATA_W-1:0] res_flat
);

    logic [DATA_W-1:0] slot_q [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (we && (waddr == AW'(g))) begin
                slot_q[g] <= wdata;
            end
        end
        assign res_flat[g*DATA_W +: DATA_W] = slot_q[g];
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [SEL_W-1:0]         sel_i,
    input  logic                     multi_i,
    input  logic                     len8_i,
    input  logic                     once_i,
    input  logic                     ack_i,
    output logic                     conv_req_o,
    output logic [SEL_W-1:0]         conv_chan_o,
    input  logic                     conv_done_i,
    input  logic [DATA_W-1:0]        conv_data_i,
    output logic [NUM_CH*DATA_W-1:0] res_o,
    output logic                     seq_done_o
);

    seq_ctl_t          ctl_d, ctl_q;
    logic [CH_W-1:0]   last_idx;
    logic              rsv;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;

    adc_seq_len_dec u_len (
        .len8     (ctl_q.cfg.len8),
        .once     (ctl_q.cfg.once),
        .last_idx (last_idx)
    );

    adc_seq_chan_map u_map (
        .src_int (ctl_q.cfg.src_int),
        .base    (ctl_q.cfg.base),
        .multi   (ctl_q.cfg.multi),
        .idx     (ctl_q.idx),
        .chan    (conv_chan_o),
        .rsv     (rsv)
    );

    always_comb begin
        ctl_d   = ctl_q;
        wr_en   = 1'b0;
        wr_data = rsv ? '0 : conv_data_i;

        if (ack_i) begin
            ctl_d.done = 1'b0;
        end

        unique case (ctl_q.st)
            ST_IDLE: ;
            ST_REQ: begin
                ctl_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (conv_done_i) begin
                    wr_en = 1'b1;
                    if (ctl_q.idx == last_idx) begin
                        ctl_d.st = ST_FIN;
                    end else begin
                        ctl_d.idx = CH_W'(ctl_q.idx + 1'b1);
                        ctl_d.st  = ST_REQ;
                    end
                end
            end
            ST_FIN: begin
                ctl_d.st   = ST_IDLE;
                ctl_d.done = 1'b1;
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        // a start always wins: abort and reload
        if (start_i) begin
            wr_en               = 1'b0;
            ctl_d.st            = ST_REQ;
            ctl_d.idx           = '0;
            ctl_d.done          = 1'b0;
            ctl_d.cfg.src_int   = sel_i[SEL_W-1];
            ctl_d.cfg.base      = sel_i[CH_W-1:0];
            ctl_d.cfg.multi     = multi_i;
            ctl_d.cfg.len8      = len8_i;
            ctl_d.cfg.once      = once_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, cfg: '0, idx: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    adc_seq_res_bank #(
        .DATA_W (DATA_W),
        .NUM    (NUM_CH)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_en),
        .waddr    (ctl_q.idx),
        .wdata    (wr_data),
        .res_flat (res_o)
    );

    assign conv_req_o = (ctl_q.st == ST_REQ);
    assign seq_done_o = ctl_q.done;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic ack_i,
    input logic conv_req_o,
    input logic conv_done_i,
    input logic seq_done_o
);

    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (start_i) begin
            pend_q <= 1'b0;
        end else if (conv_req_o) begin
            pend_q <= 1'b1;
        end else if (conv_done_i) begin
            pend_q <= 1'b0;
        end
    end

    p_req_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req_o && !start_i |=> !conv_req_o);

    p_req_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req_o |-> !pend_q);

    p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !seq_done_o);

    p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_done_o) |-> $past(conv_done_i, 2));

    p_done_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done_o && !ack_i && !start_i |=> seq_done_o);

endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .ack_i       (ack_i),
    .conv_req_o  (conv_req_o),
    .conv_done_i (conv_done_i),
    .seq_done_o  (seq_done_o)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;

    localparam int DW  = 10;
    localparam int NR  = 8;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [3:0]    sel_i = '0;
    logic          multi_i = 1'b0;
    logic          len8_i = 1'b0;
    logic          once_i = 1'b0;
    logic          ack_i = 1'b0;
    logic          conv_req_o;
    logic [3:0]    conv_chan_o;
    logic          conv_done_i;
    logic [DW-1:0] conv_data_i;
    logic [NR*DW-1:0] res_o;
    logic          seq_done_o;

    adc_seq_ctrl #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i),
        .multi_i(multi_i), .len8_i(len8_i), .once_i(once_i), .ack_i(ack_i),
        .conv_req_o(conv_req_o), .conv_chan_o(conv_chan_o),
        .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
        .res_o(res_o), .seq_done_o(seq_done_o)
    );

    always #5 clk = ~clk;

    typedef struct {
        int       slot;
        logic [3:0] ch;
        bit       rsv;
        string    tag;
    } exp_t;

    exp_t          exp_q[$];
    exp_t          pend;
    logic [DW-1:0] shadow [NR];
    int total = 0;
    int bad = 0;
    int cyc = 0;
    int cnt = 0;
    int nreq = 0;
    int last_done_cyc = 0;
    int salt = 0;
    bit prev_req = 1'b0;
    bit stray = 1'b0;
    bit finished = 1'b0;

    function automatic logic [DW-1:0] mk(logic [3:0] ch, int s);
        return DW'((int'(ch) * 53 + s * 11 + 7) % 1024);
    endfunction

    function automatic bit is_rsv(logic [3:0] ch);
        return ch[3] && !(ch[2:0] inside {3'd4, 3'd5, 3'd6});
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // converter model and scoreboard monitor
    initial begin
        conv_done_i = 1'b0;
        conv_data_i = '0;
        forever begin
            @(negedge clk);
            cyc++;
            conv_done_i = 1'b0;
            if (start_i) cnt = 0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    conv_done_i = 1'b1;
                    conv_data_i = mk(pend.ch, salt);
                    shadow[pend.slot] = pend.rsv ? '0 : mk(pend.ch, salt);
                    last_done_cyc = cyc;
                end
            end
            if (conv_req_o) begin
                nreq++;
                chk("R6 request width", 32'(prev_req && !start_i), 32'd0);
                if (exp_q.size() == 0) begin
                    chk("R6 unexpected request", 32'd1, 32'd0);
                end else begin
                    pend = exp_q.pop_front();
                    chk(pend.tag, 32'(conv_chan_o), 32'(pend.ch));
                    cnt = LAT;
                end
            end
            if (stray) begin
                conv_done_i = 1'b1;
                conv_data_i = '1;
                stray = 1'b0;
            end
            prev_req = conv_req_o;
        end
    end

    task automatic go(logic [3:0] sel, bit m, bit l8, bit o, int s, string tag);
        int len;
        @(negedge clk); #1;
        salt = s;
        exp_q.delete();
        len = l8 ? 8 : (o ? 1 : 4);
        for (int n = 0; n < len; n++) begin
            exp_t it;
            it.slot = n;
            it.ch   = m ? {sel[3], 3'(sel[2:0] + 3'(n))} : sel;
            it.rsv  = is_rsv(it.ch);
            it.tag  = tag;
            exp_q.push_back(it);
        end
        sel_i = sel; multi_i = m; len8_i = l8; once_i = o;
        start_i = 1'b1;
        nreq = 0;
        @(negedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic wait_done(string tag);
        int k = 0;
        while (!seq_done_o && k < 2000) begin
            @(negedge clk); #1;
            k++;
        end
        chk({tag, " R8 flag raised"}, 32'(seq_done_o), 32'd1);
        chk({tag, " R8 flag one cycle after last write"}, 32'(cyc - last_done_cyc), 32'd2);
        chk({tag, " all conversions requested"}, 32'(exp_q.size()), 32'd0);
    endtask

    task automatic check_regs(string tag);
        for (int r = 0; r < NR; r++) begin
            chk($sformatf("%s reg%0d", tag, r), 32'(res_o[r*DW +: DW]), 32'(shadow[r]));
        end
    endtask

    initial begin
        for (int r = 0; r < NR; r++) shadow[r] = '0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 flag after reset", 32'(seq_done_o), 32'd0);
        chk("R1 no request after reset", 32'(conv_req_o), 32'd0);
        check_regs("R1 reset");
        rst_n = 1'b1;

        // R2: wrap from 3, then no wrap from 0
        go(4'd3, 1, 1, 0, 1, "R2 chan start3");
        wait_done("R2a");
        check_regs("R2 start3");
        go(4'd0, 1, 1, 0, 2, "R2 chan start0");
        wait_done("R2b");
        check_regs("R2 start0");

        // R3: four-long multichannel from 6, regs 4..7 kept
        go(4'd6, 1, 0, 0, 3, "R3 chan start6");
        wait_done("R3");
        check_regs("R3 short");

        // R4: single channel, four and eight long
        go(4'd5, 0, 0, 0, 4, "R4 chan single4");
        wait_done("R4a");
        check_regs("R4 single4");
        go(4'd2, 0, 1, 0, 5, "R4 chan single8");
        wait_done("R4b");
        check_regs("R4 single8");

        // R5: one-shot, then eight-long overriding one-shot
        go(4'd7, 1, 0, 1, 6, "R5 chan oneshot");
        wait_done("R5a");
        check_regs("R5 oneshot");
        go(4'd1, 1, 1, 1, 7, "R5 chan override");
        wait_done("R5b");
        check_regs("R5 override");

        // R9: internal valid, internal reserved, mixed eight-long
        go(4'b1101, 0, 0, 0, 8, "R9 chan int valid");
        wait_done("R9a");
        check_regs("R9 int valid");
        go(4'b1001, 0, 0, 1, 9, "R9 chan int reserved");
        wait_done("R9b");
        check_regs("R9 int reserved");
        go(4'b1100, 1, 1, 0, 10, "R9 chan int mixed");
        wait_done("R9c");
        check_regs("R9 int mixed");

        // R8: flag holds, ack clears
        repeat (5) @(negedge clk);
        #1;
        chk("R8 flag holds", 32'(seq_done_o), 32'd1);
        @(negedge clk); #1; ack_i = 1'b1;
        @(negedge clk); #1; ack_i = 1'b0;
        chk("R8 ack clears flag", 32'(seq_done_o), 32'd0);

        // R6: done pulse while idle is ignored
        @(negedge clk); #1; stray = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        chk("R6 stray done no flag", 32'(seq_done_o), 32'd0);
        chk("R6 stray done no request", 32'(conv_req_o), 32'd0);
        check_regs("R6 stray done");

        // R7: abort mid-sequence, restart with new settings
        go(4'd2, 1, 1, 0, 11, "R7 chan aborted");
        while (nreq < 3) begin
            @(negedge clk); #1;
        end
        go(4'd5, 1, 0, 0, 12, "R7 chan restart");
        wait_done("R7a");
        check_regs("R7 after abort");

        // R7: restart after completion clears flag
        go(4'b0100, 0, 0, 1, 13, "R7 chan refresh");
        chk("R7 start clears flag", 32'(seq_done_o), 32'd0);
        wait_done("R7b");
        check_regs("R7 refresh");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(negedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule